// File: doc/BRIEF.md
# Step/Direction Microstep Sequencer

This block turns a step pulse train and a direction level into the two winding setpoints of a two-phase stepper motor, with no processor involved. An electrical-angle index of 64 positions per cycle moves once per rising edge of the step input. It moves up when the direction input is high and down when it is low. A quarter-wave sine table, mirrored and sign-extended, turns the index into a sign bit and a 7-bit magnitude for each winding. Phase A follows sin(index) and phase B follows cos(index). The magnitudes feed the current references of the motor drivers, and the sign bits feed their phase inputs.

A 3-bit drive-style input sets how far each step pulse moves the index, and which grid of positions it may land on. The styles are fine microstepping, quarter step, half step, two-phase-on full step and single-phase wave drive. The step input is asynchronous. It is synchronised and then edge-detected by a two-state machine: ST_ARMED waits for step high, and ST_HELD waits for step low. The transition ARMED->HELD is the only one that accepts a step. The transition HELD->ARMED re-arms the detector.

Top module: `stepdrive_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the index to 0. The outputs then read phase A magnitude 0 with sign 0, and phase B magnitude 127 with sign 0.
- R2: Each rising edge of `step_in` is accepted exactly once. Holding `step_in` high for any number of cycles causes no further movement.
- R3: With `dir_in` = 1 an accepted step raises the index, and with `dir_in` = 0 it lowers it. The index wraps modulo 64 in both directions (63 up to 0, 0 down to 63).
- R4: Phase A magnitude is round(127·|sin(2π·i/64)|) and phase B magnitude is round(127·|cos(2π·i/64)|) for index i. Each sign output is 1 only when its value is negative with a nonzero magnitude, so code 0 always carries sign 0.
- R5: `mode_in` codes set the stride per step: 0 is microstep (1), 1 is quarter step (4), 2 is half step (8), 3 is full step (16, grid offset 8) and 4 is wave drive (16, grid offset 0). Codes 5 to 7 act as microstep.
- R6: In a mode with stride s and offset o, a step from an index that is not on the grid {o + k·s} moves to the nearest grid point in the step's direction. A step from a grid point moves by exactly s.
- R7: The index changes on the clock edge two cycles after the first edge that samples `step_in` high. The outputs follow one edge later. No other input change alters the outputs.
- R8: Full-step positions drive both windings at magnitude 90. Wave-drive positions drive one winding at 127 and the other at 0.
- R9: `dir_in` and `mode_in` are taken in the cycle in which a step is accepted into the index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_in | input | 1 | Asynchronous step pulse; each rising edge moves the index |
| dir_in | input | 1 | 1 = count up, 0 = count down |
| mode_in | input | 3 | Drive style: 0 micro, 1 quarter, 2 half, 3 full, 4 wave, 5-7 micro |
| a_mag | output | 7 | Phase A magnitude (sine) |
| a_neg | output | 1 | Phase A sign, 1 = reversed current |
| b_mag | output | 7 | Phase B magnitude (cosine) |
| b_neg | output | 1 | Phase B sign, 1 = reversed current |

## Verification
A step that is first seen high at clock edge E0 moves the index at E2 and the winding outputs at E3. A reset applied at an edge sets the outputs at that same edge. The bench reference model reproduces this by carrying each accepted step through a two-entry delay list before it updates a behavioural index. It forms the expected outputs from the index value held before the current edge, and compares all four outputs on every falling edge. Direction and mode stay constant for at least three cycles after each pulse goes low, so they are stable at the edge where the step is taken. Stretches in which direction and mode toggle with no step confirm that the outputs stay constant.

// File: rtl/stepdrive_pkg.sv
package stepdrive_pkg;

    localparam int IDX_W = 6;                 // 64 positions per electrical cycle
    localparam int MAG_W = 7;                 // 128 magnitude levels
    localparam int QTR   = 1 << (IDX_W - 2);  // positions per quadrant
    localparam int KW    = IDX_W - 1;         // width of a 0..QTR table address

    localparam logic [2:0] MODE_MICRO   = 3'd0;
    localparam logic [2:0] MODE_QUARTER = 3'd1;
    localparam logic [2:0] MODE_HALF    = 3'd2;
    localparam logic [2:0] MODE_FULL    = 3'd3;
    localparam logic [2:0] MODE_WAVE    = 3'd4;

    typedef enum logic {
        ST_ARMED,
        ST_HELD
    } edge_state_e;

    // round(127 * sin(k * 90deg / 16)) for k = 0..16
    function automatic logic [MAG_W-1:0] quarter_sine(input logic [KW-1:0] k);
        logic [MAG_W-1:0] v;
        unique case (k)
            5'd0:  v = 7'd0;
            5'd1:  v = 7'd12;
            5'd2:  v = 7'd25;
            5'd3:  v = 7'd37;
            5'd4:  v = 7'd49;
            5'd5:  v = 7'd60;
            5'd6:  v = 7'd71;
            5'd7:  v = 7'd81;
            5'd8:  v = 7'd90;
            5'd9:  v = 7'd98;
            5'd10: v = 7'd106;
            5'd11: v = 7'd112;
            5'd12: v = 7'd117;
            5'd13: v = 7'd122;
            5'd14: v = 7'd125;
            5'd15: v = 7'd126;
            default: v = 7'd127;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/step_edge_fsm.sv
module step_edge_fsm (
    input  logic clk,
    input  logic rst,
    input  logic step_raw,
    output logic adv
);
    import stepdrive_pkg::*;

    logic        sync1_q, sync2_q;
    edge_state_e state_q, state_d;

    // two-flop synchroniser for the asynchronous step input
    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= step_raw;
            sync2_q <= sync1_q;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ARMED;
        else     state_q <= state_d;
    end

    // next state and accept pulse
    always_comb begin
        state_d = state_q;
        adv     = 1'b0;
        unique case (state_q)
            ST_ARMED: if (sync2_q) begin
                state_d = ST_HELD;
                adv     = 1'b1;
            end
            ST_HELD: if (!sync2_q) state_d = ST_ARMED;
            default: state_d = ST_ARMED;
        endcase
    end

endmodule

// File: rtl/step_index.sv
module step_index (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           adv,
    input  logic                           dir_up,
    input  logic [2:0]                     mode,
    output logic [stepdrive_pkg::IDX_W-1:0] idx
);
    import stepdrive_pkg::*;

    logic [IDX_W-1:0] stride, offs, rel, base, nxt_rel, idx_q;

    always_comb begin
        offs = '0;
        unique case (mode)
            MODE_QUARTER: stride = IDX_W'(QTR / 4);
            MODE_HALF:    stride = IDX_W'(QTR / 2);
            MODE_FULL: begin
                stride = IDX_W'(QTR);
                offs   = IDX_W'(QTR / 2);
            end
            MODE_WAVE:    stride = IDX_W'(QTR);
            default:      stride = IDX_W'(1);
        endcase
        rel  = idx_q - offs;
        base = rel & ~(stride - IDX_W'(1));
        if (dir_up)              nxt_rel = base + stride;
        else if (rel == base)    nxt_rel = base - stride;
        else                     nxt_rel = base;
    end

    always_ff @(posedge clk) begin
        if (rst)      idx_q <= '0;
        else if (adv) idx_q <= nxt_rel + offs;
    end

    assign idx = idx_q;

endmodule

// File: rtl/phase_lookup.sv
module phase_lookup #(
    parameter int OFFSET = 0
) (
    input  logic [stepdrive_pkg::IDX_W-1:0] idx,
    output logic [stepdrive_pkg::MAG_W-1:0] mag,
    output logic                            neg
);
    import stepdrive_pkg::*;

    logic [IDX_W-1:0] pos;
    logic [1:0]       quad;
    logic [KW-1:0]    k, kk;

    always_comb begin
        pos  = idx + IDX_W'(OFFSET);
        quad = pos[IDX_W-1:IDX_W-2];
        k    = {1'b0, pos[IDX_W-3:0]};
        kk   = quad[0] ? (KW'(QTR) - k) : k;
        mag  = quarter_sine(kk);
        neg  = quad[1] && (mag != '0);
    end

endmodule

// File: rtl/stepdrive_seq.sv
module stepdrive_seq (
    input  logic       clk,
    input  logic       rst,
    input  logic       step_in,
    input  logic       dir_in,
    input  logic [2:0] mode_in,
    output logic [6:0] a_mag,
    output logic       a_neg,
    output logic [6:0] b_mag,
    output logic       b_neg
);
    import stepdrive_pkg::*;

    logic             adv;
    logic [IDX_W-1:0] idx_q;
    logic [MAG_W-1:0] mag_w [2];
    logic             neg_w [2];

    step_edge_fsm u_edge (
        .clk      (clk),
        .rst      (rst),
        .step_raw (step_in),
        .adv      (adv)
    );

    step_index u_index (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv),
        .dir_up (dir_in),
        .mode   (mode_in),
        .idx    (idx_q)
    );

    // phase 0 = sine (A), phase 1 = cosine (B, a quarter cycle ahead)
    for (genvar p = 0; p < 2; p++) begin : g_phase
        phase_lookup #(.OFFSET(p * QTR)) u_lut (
            .idx (idx_q),
            .mag (mag_w[p]),
            .neg (neg_w[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_mag <= '0;
            a_neg <= 1'b0;
            b_mag <= MAG_W'((1 << MAG_W) - 1);
            b_neg <= 1'b0;
        end else begin
            a_mag <= mag_w[0];
            a_neg <= neg_w[0];
            b_mag <= mag_w[1];
            b_neg <= neg_w[1];
        end
    end

endmodule

// File: rtl/stepdrive_seq_chk.sv
module stepdrive_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       dir_in,
    input logic [2:0] mode_in,
    input logic       adv,
    input logic [5:0] idx,
    input logic [6:0] a_mag,
    input logic       a_neg,
    input logic [6:0] b_mag,
    input logic       b_neg
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (a_mag == 7'd0 && !a_neg && b_mag == 7'd127 && !b_neg));

    p_single_accept_r2: assert property (@(posedge clk) disable iff (rst)
        adv |=> !adv);

    p_micro_up_r3: assert property (@(posedge clk) disable iff (rst)
        (adv && mode_in == 3'd0 && dir_in) |=> (idx == $past(idx) + 6'd1));

    p_micro_down_r3: assert property (@(posedge clk) disable iff (rst)
        (adv && mode_in == 3'd0 && !dir_in) |=> (idx == $past(idx) - 6'd1));

    p_a_zero_pos_r4: assert property (@(posedge clk) disable iff (rst)
        (a_mag == 7'd0) |-> !a_neg);

    p_b_zero_pos_r4: assert property (@(posedge clk) disable iff (rst)
        (b_mag == 7'd0) |-> !b_neg);

    p_full_grid_r5: assert property (@(posedge clk) disable iff (rst)
        (adv && mode_in == 3'd3) |=> (idx[3:0] == 4'd8));

    p_wave_grid_r5: assert property (@(posedge clk) disable iff (rst)
        (adv && mode_in == 3'd4) |=> (idx[3:0] == 4'd0));

    p_idx_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(idx));

    p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
        $stable(idx) |=> ($stable(a_mag) && $stable(a_neg) && $stable(b_mag) && $stable(b_neg)));

endmodule

bind stepdrive_seq stepdrive_seq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .dir_in  (dir_in),
    .mode_in (mode_in),
    .adv     (adv),
    .idx     (idx_q),
    .a_mag   (a_mag),
    .a_neg   (a_neg),
    .b_mag   (b_mag),
    .b_neg   (b_neg)
);

// File: tb/stepdrive_seq_tb.sv
module stepdrive_seq_tb;

    logic       clk = 1'b0;
    logic       drv_rst = 1'b1;
    logic       drv_step = 1'b0;
    logic       drv_dir = 1'b1;
    logic [2:0] drv_mode = 3'd0;
    logic [6:0] a_mag, b_mag;
    logic       a_neg, b_neg;

    always #4 clk = ~clk;   // 125 MHz

    stepdrive_seq u_dut (
        .clk     (clk),
        .rst     (drv_rst),
        .step_in (drv_step),
        .dir_in  (drv_dir),
        .mode_in (drv_mode),
        .a_mag   (a_mag),
        .a_neg   (a_neg),
        .b_mag   (b_mag),
        .b_neg   (b_neg)
    );

    // behavioural reference state
    int    m_idx = 0;
    bit    m_prev = 0;
    bit    pend_v[$];
    bit    pend_d[$];
    int    pend_m[$];
    int    vectors = 0;
    int    errors = 0;
    string req = "R1";
    bit    done = 0;

    function automatic real sin_val(int i);
        return $sin(2.0 * 3.14159265358979 * i / 64.0);
    endfunction

    function automatic int mag_of(int i);
        real v;
        v = 127.0 * sin_val(i);
        if (v < 0.0) v = -v;
        return $rtoi(v + 0.5);
    endfunction

    function automatic bit neg_of(int i);
        return (sin_val(i) < 0.0) && (mag_of(i) != 0);
    endfunction

    function automatic int next_pos(int i, bit up, int mode);
        int s, o, r;
        case (mode)
            1: begin s = 4;  o = 0; end
            2: begin s = 8;  o = 0; end
            3: begin s = 16; o = 8; end
            4: begin s = 16; o = 0; end
            default: begin s = 1; o = 0; end
        endcase
        r = (i - o + 64) % 64;
        if (up)              r = (r / s) * s + s;
        else if (r % s == 0) r = r - s;
        else                 r = (r / s) * s;
        return (r + o + 128) % 64;
    endfunction

    task automatic tick();
        int ea, eb;
        bit ean, ebn;
        @(negedge clk);
        if (drv_rst) begin
            m_idx = 0;
            m_prev = 0;
            pend_v = '{0, 0};
            pend_d = '{0, 0};
            pend_m = '{0, 0};
            ea = 0; ean = 0; eb = 127; ebn = 0;
        end else begin
            ea  = mag_of(m_idx);
            ean = neg_of(m_idx);
            eb  = mag_of(m_idx + 16);
            ebn = neg_of(m_idx + 16);
            if (pend_v[0]) m_idx = next_pos(m_idx, pend_d[0], pend_m[0]);
            void'(pend_v.pop_front());
            void'(pend_d.pop_front());
            void'(pend_m.pop_front());
            pend_v.push_back(drv_step && !m_prev);
            pend_d.push_back(drv_dir);
            pend_m.push_back(int'(drv_mode));
            m_prev = drv_step;
        end
        vectors++;
        if (a_mag !== 7'(ea) || a_neg !== ean || b_mag !== 7'(eb) || b_neg !== ebn) begin
            errors++;
            $display("FAIL %s: got A=%0d/%0b B=%0d/%0b expected A=%0d/%0b B=%0d/%0b",
                     req, a_mag, a_neg, b_mag, b_neg, ea, ean, eb, ebn);
        end
    endtask

    task automatic pulse(bit d, int m, int hi, int lo);
        drv_dir  = d;
        drv_mode = 3'(m);
        drv_step = 1'b1;
        repeat (hi) tick();
        drv_step = 1'b0;
        repeat (lo) tick();
    endtask

    initial begin
        pend_v = '{0, 0};
        pend_d = '{0, 0};
        pend_m = '{0, 0};
        req = "R1 reset state";
        repeat (3) tick();
        drv_rst = 1'b0;
        repeat (2) tick();

        req = "R3/R4/R7/R9 micro up with wrap";
        for (int n = 0; n < 70; n++) pulse(1'b1, 0, 2, 3);
        req = "R3/R4/R9 micro down with wrap";
        for (int n = 0; n < 75; n++) pulse(1'b0, 0, 1 + (n % 3), 3);

        req = "R2 long high pulses";
        for (int n = 0; n < 6; n++) pulse(n % 2 == 0, 0, 12, 4);

        req = "R5 quarter up";
        for (int n = 0; n < 18; n++) pulse(1'b1, 1, 2, 3);
        req = "R5 half down";
        for (int n = 0; n < 10; n++) pulse(1'b0, 2, 2, 3);
        req = "R5 codes 5-7 as micro";
        for (int m = 5; m < 8; m++) begin
            pulse(1'b1, m, 2, 3);
            pulse(1'b1, m, 2, 3);
        end

        req = "R6/R8 full from off-grid";
        pulse(1'b1, 0, 2, 3);
        for (int n = 0; n < 6; n++) pulse(1'b1, 3, 2, 3);
        req = "R6/R8 wave down from off-grid";
        for (int n = 0; n < 3; n++) pulse(1'b0, 0, 2, 3);
        for (int n = 0; n < 6; n++) pulse(1'b0, 4, 2, 3);
        req = "R6/R8 full down and quarter from off-grid";
        pulse(1'b1, 0, 2, 3);
        for (int n = 0; n < 5; n++) pulse(1'b0, 3, 2, 3);
        pulse(1'b1, 0, 2, 3);
        pulse(1'b0, 1, 2, 3);
        pulse(1'b1, 2, 2, 3);

        req = "R7 dir/mode changes without step";
        for (int n = 0; n < 12; n++) begin
            drv_dir  = n[0];
            drv_mode = 3'(n % 8);
            tick();
        end
        req = "R7 single step latency";
        pulse(1'b1, 0, 1, 10);

        req = "R1 reset mid-run";
        drv_rst = 1'b1;
        repeat (2) tick();
        drv_rst = 1'b0;
        repeat (2) tick();
        pulse(1'b0, 0, 2, 4);
        pulse(1'b1, 4, 2, 4);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule